// File: doc/BRIEF.md
# CAN Receive Bit Destuffer

This block sits between the bit sampler and the frame parser of a CAN receiver. Each cycle in which `bitValid` is high carries one sampled bus bit. The block classifies that bit. A frame bit is forwarded with its own strobe and its position in the frame. A stuff bit, which the transmitter inserted after a run of five equal bits, is flagged and dropped.

Runs are tracked over the raw stream, so a stuff bit can open the next run. The parser marks the start of each frame with `frameStart` and supplies the index of the last data bit. From that index the block works out where stuffing ends: the CRC delimiter is the last bit that is checked, and the ACK fields and end of frame are never destuffed. The block only classifies bits. It raises no stuff-error indication and never drives the bus.

Top module: `can_destuff`

## Requirements
- R1: After reset, `frameBitValid` and `stuffFlag` are 0 and `frameIdx` is 0.
- R2: A bit is a stuff bit when it follows at least five equal raw bits and has the opposite value. A stuff bit pulses `stuffFlag` for one cycle and is not forwarded. Every result appears in the cycle after the `bitValid` cycle that carried the bit.
- R3: A sixth bit equal to the preceding run of five is forwarded as a frame bit, not as a stuff bit.
- R4: A stuff bit stays in the raw history. With the stuff bit and the four bits after it all at one value, the next opposite bit is a stuff bit.
- R5: Forwarded bits carry consecutive values on `frameIdx`, starting at 0 for the bit that arrives with `frameStart`. A stuff bit does not advance the index, and `frameIdx` holds its last value while `stuffFlag` is high.
- R6: `frameStart` empties the raw history. The bit that arrives with it is never a stuff bit, and it opens the first run of the frame.
- R7: Stuffing is checked only while the index the next frame bit would receive is at most `lastDataIdx + 16`. Beyond that point every bit is forwarded.
- R8: `frameBitValid` and `stuffFlag` are never high together, and `frameBit` carries the value of the forwarded input bit.
- R9: A cycle with `bitValid` low produces no pulse on either output and leaves `frameIdx` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Marks the start of a frame. It may arrive in the same cycle as the first bit of the frame. |
| bitValid | input | 1 | `bitIn` holds a sampled bit |
| bitIn | input | 1 | Sampled bus bit (0 = dominant) |
| lastDataIdx | input | IDX_W | Frame index of the last data bit, supplied by the parser |
| frameBitValid | output | 1 | One-cycle pulse: a frame bit is forwarded |
| frameBit | output | 1 | Value of the forwarded frame bit |
| stuffFlag | output | 1 | One-cycle pulse: the input bit was a stuff bit and was dropped |
| frameIdx | output | IDX_W | Frame index of the most recently forwarded bit |

## Verification
Each classification is registered once, so it is due exactly one cycle after the `bitValid` cycle that carried the bit. The bench drives each bit on a falling edge and reads all outputs on the next falling edge, when the result for that bit is already registered. The index is checked after every bit, including stuff bits and empty cycles, so a wrong advance shows up at once. Directed frames cover clearing the history at frame start and both sides of the end-of-stuffing boundary.

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;
  // Strobes passed from control to datapath for the current input cycle
  typedef struct packed {
    logic restart;  // frame start seen this cycle
    logic fwd;      // input bit is a frame bit
    logic stuff;    // input bit is a stuff bit
  } dsStrobe_t;
endpackage

// File: rtl/can_destuff_ctrl.sv
module can_destuff_ctrl
  import can_destuff_pkg::*;
#(
  parameter int RUN_LEN    = 5,
  parameter int IDX_W      = 8,
  parameter int STUFF_TAIL = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic [IDX_W-1:0] nextIdx,
  input  logic [IDX_W-1:0] lastDataIdx,
  output dsStrobe_t        strobe
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] runCnt;
  logic             runVal;
  logic [CNT_W-1:0] effCnt;
  logic [IDX_W-1:0] idxNow;
  logic [IDX_W:0]   stuffLimit;
  logic             stuffOn;
  logic             isStuff;

  always_comb begin
    effCnt     = frameStart ? '0 : runCnt;
    idxNow     = frameStart ? '0 : nextIdx;
    stuffLimit = {1'b0, lastDataIdx} + (IDX_W + 1)'(STUFF_TAIL);
    stuffOn    = ({1'b0, idxNow} <= stuffLimit);
    isStuff    = bitValid && stuffOn && (effCnt == RUN_MAX) && (bitIn != runVal);
    strobe.restart = frameStart;
    strobe.fwd     = bitValid && !isStuff;
    strobe.stuff   = isStuff;
  end

  // Raw run tracker: stuff bits count as history too
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
      runVal <= 1'b0;
    end else if (bitValid) begin
      if ((effCnt != '0) && (bitIn == runVal)) begin
        runCnt <= (effCnt == RUN_MAX) ? effCnt : effCnt + 1'b1;
      end else begin
        runCnt <= CNT_W'(1);
        runVal <= bitIn;
      end
    end else if (frameStart) begin
      runCnt <= '0;
    end
  end

  p_run_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_MAX);

  p_stuff_spaced_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stuff |=> !strobe.stuff);

  p_sof_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !strobe.stuff);
endmodule

// File: rtl/can_destuff_dp.sv
module can_destuff_dp
  import can_destuff_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dsStrobe_t        strobe,
  input  logic             bitIn,
  output logic [IDX_W-1:0] nextIdx,
  output logic             outValid,
  output logic             outBit,
  output logic             outStuff,
  output logic [IDX_W-1:0] outIdx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idxNow;

  always_comb idxNow = strobe.restart ? '0 : nextIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextIdx  <= '0;
      outValid <= 1'b0;
      outBit   <= 1'b0;
      outStuff <= 1'b0;
      outIdx   <= '0;
    end else begin
      outValid <= strobe.fwd;
      outStuff <= strobe.stuff;
      if (strobe.fwd) begin
        outBit  <= bitIn;
        outIdx  <= idxNow;
        nextIdx <= (idxNow == IDX_MAX) ? idxNow : idxNow + 1'b1;
      end else if (strobe.restart) begin
        nextIdx <= '0;
      end
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outStuff));

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    outStuff |-> $stable(outIdx));
endmodule

// File: rtl/can_destuff.sv
module can_destuff
  import can_destuff_pkg::*;
#(
  parameter int RUN_LEN    = 5,
  parameter int IDX_W      = 8,
  parameter int STUFF_TAIL = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic [IDX_W-1:0] lastDataIdx,
  output logic             frameBitValid,
  output logic             frameBit,
  output logic             stuffFlag,
  output logic [IDX_W-1:0] frameIdx
);
  dsStrobe_t        strobe;
  logic [IDX_W-1:0] nextIdx;

  can_destuff_ctrl #(
    .RUN_LEN(RUN_LEN), .IDX_W(IDX_W), .STUFF_TAIL(STUFF_TAIL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .nextIdx(nextIdx), .lastDataIdx(lastDataIdx),
    .strobe(strobe)
  );

  can_destuff_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIn(bitIn),
    .nextIdx(nextIdx), .outValid(frameBitValid), .outBit(frameBit),
    .outStuff(stuffFlag), .outIdx(frameIdx)
  );

  p_out_follows_in_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameBitValid || stuffFlag) |-> $past(bitValid));
endmodule

// File: tb/can_destuff_tb.sv
`timescale 1ns/1ps
module can_destuff_tb;
  localparam int IDX_W = 8;
  localparam int NVEC  = 19;

  logic             clk = 1'b0;
  logic             rstN;
  logic             frameStart;
  logic             bitValid;
  logic             bitIn;
  logic [IDX_W-1:0] lastDataIdx;
  logic             frameBitValid;
  logic             frameBit;
  logic             stuffFlag;
  logic [IDX_W-1:0] frameIdx;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_destuff u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .lastDataIdx(lastDataIdx), .frameBitValid(frameBitValid),
    .frameBit(frameBit), .stuffFlag(stuffFlag), .frameIdx(frameIdx)
  );

  // {start, valid, bit, expValid, expStuff, expIdx[7:0]}
  localparam logic [12:0] TBL [NVEC] = '{
    {5'b11010, 8'd0},   // SOF, opens run of zeros
    {5'b01010, 8'd1},
    {5'b01010, 8'd2},
    {5'b01010, 8'd3},
    {5'b01010, 8'd4},   // five zeros
    {5'b01101, 8'd4},   // R2 stuff one
    {5'b01110, 8'd5},
    {5'b01110, 8'd6},
    {5'b01110, 8'd7},
    {5'b01110, 8'd8},   // stuff + four ones
    {5'b01001, 8'd8},   // R4 stuff zero
    {5'b01010, 8'd9},
    {5'b00000, 8'd9},   // R9 idle cycle
    {5'b01010, 8'd10},
    {5'b01010, 8'd11},
    {5'b01010, 8'd12},
    {5'b01010, 8'd13},  // R3 sixth zero forwarded
    {5'b01101, 8'd13},  // R2 stuff after six zeros
    {5'b11110, 8'd0}    // R5 new frame restarts index
  };

  task automatic checkOut(input logic eV, input logic eS, input logic eB,
                          input logic [IDX_W-1:0] eI, input string req);
    checks++;
    if (frameBitValid !== eV || stuffFlag !== eS || frameIdx !== eI ||
        (eV && frameBit !== eB)) begin
      failures++;
      $display("FAIL %s: valid=%0b stuff=%0b bit=%0b idx=%0d expected valid=%0b stuff=%0b bit=%0b idx=%0d",
               req, frameBitValid, stuffFlag, frameBit, frameIdx, eV, eS, eB, eI);
    end
  endtask

  // Drive at a falling edge, check one falling edge later
  task automatic sendBit(input logic st, input logic vl, input logic b,
                         input logic eV, input logic eS,
                         input logic [IDX_W-1:0] eI, input string req);
    frameStart = st;
    bitValid   = vl;
    bitIn      = b;
    @(negedge clk);
    frameStart = 1'b0;
    bitValid   = 1'b0;
    checkOut(eV, eS, b, eI, req);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameStart = 1'b0; bitValid = 1'b0; bitIn = 1'b0;
    lastDataIdx = 8'd100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b0, 1'b0, 1'b0, 8'd0, "R1 reset state");

    // Table walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      sendBit(TBL[i][12], TBL[i][11], TBL[i][10], TBL[i][9], TBL[i][8],
              TBL[i][7:0], $sformatf("R2/R3/R4/R5/R8/R9 vector %0d", i));
    end

    // R6: frame start empties history; four ones then start with a one
    sendBit(1, 1, 0, 1, 0, 8'd0, "R6 sof");
    for (int k = 1; k <= 4; k++) sendBit(0, 1, 1, 1, 0, IDX_W'(k), "R6 ones");
    sendBit(1, 1, 1, 1, 0, 8'd0, "R6 start bit not stuff");
    sendBit(0, 1, 0, 1, 0, 8'd1, "R6 run restarted at frame start");

    // R7 upper side: lastDataIdx = 0, run of five ones after index 16
    lastDataIdx = 8'd0;
    for (int k = 0; k <= 16; k++)
      sendBit(k == 0, 1, logic'(k % 2), 1, 0, IDX_W'(k), "R7 alternating");
    for (int k = 17; k <= 21; k++) sendBit(0, 1, 1, 1, 0, IDX_W'(k), "R7 ones");
    sendBit(0, 1, 0, 1, 0, 8'd22, "R7 past limit no stuffing");

    // R7 lower side: stuff bit while next index is exactly 16
    for (int k = 0; k <= 10; k++)
      sendBit(k == 0, 1, logic'(k % 2), 1, 0, IDX_W'(k), "R7 alternating");
    for (int k = 11; k <= 15; k++) sendBit(0, 1, 1, 1, 0, IDX_W'(k), "R7 ones");
    sendBit(0, 1, 0, 0, 1, 8'd15, "R7 stuff at limit");
    sendBit(0, 1, 0, 1, 0, 8'd16, "R7 crc delimiter index");

    // R1: reset mid-frame clears outputs
    bitValid = 1'b1; bitIn = 1'b1; rstN = 1'b0;
    @(negedge clk);
    bitValid = 1'b0; rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b0, 1'b0, 1'b0, 8'd0, "R1 reset mid-frame");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule